// File: doc/BRIEF.md
# SD Command Issue Unit

This block issues one SD card command at a time and follows it to completion. Software programs a 32-bit argument and a 16-bit command word through a small register port. Setting the go flag in the command word starts the command. The block serialises the 48-bit command frame onto the CMD line, one bit per card-clock strobe. It then waits for the card's answer, captures a short (48-bit) or long (136-bit) response into four 32-bit response words and checks the response CRC7. When a busy-wait is asked for, it also watches DAT0 until the card lets go of it.

Hardware clears the go flag once the command phase is over, whether the command succeeded or failed. A fail flag next to it stays set until the next accepted command write. Error and event causes collect in a status register whose bits software clears by writing 1 to them. The card clock itself is generated elsewhere. This block sees it only as a one-cycle `bit_tick` strobe, and it advances the CMD line state only on that strobe.

Top module: `sdcmd_issue`

## Requirements
- R1: After reset every readable register (command at address 0, argument at 1, status at 2, response words at 4 to 7) reads 0, `cmd_oe` is 0 and `cmd_out` is 1.
- R2: The command word reads back as: bit 15 go, bit 14 fail, bit 11 busy-wait, bit 10 no-response, bit 9 long response, bit 7 write, bit 6 read, bits 5:0 index. All other bits read 0, and software cannot set the fail bit. A write with go clear only stores the fields. The argument register reads back what was written.
- R3: After go is set, the block drives 48 bits MSB first, one per `bit_tick`: 0, 1, the index, the argument, a CRC7 and a 1 end bit. The CRC7 uses x^7+x^3+1 from a zero state over the first 40 bits. `cmd_oe` is 1 for exactly those 48 bits and 0 otherwise.
- R4: Go drops in the cycle the command phase ends. A no-response command ends on the strobe that sends its end bit, with fail 0.
- R5: A write to the command word while go is set changes no field.
- R6: After the end bit, the block counts strobes on which `cmd_in` is 1. A 0 on any of the first 64 such strobes is taken as the response start bit. A 64th high strobe ends the command with fail set and status bit 6 set.
- R7: For a short response, frame bits 39:8 go to response word 0. The CRC7 over frame bits 47:8 is compared with bits 7:1. A mismatch sets fail and status bit 4.
- R8: For a long response (136 bits), frame bits 127:0 go to response words 0 (bits 31:0) up to 3 (bits 127:96). The CRC7 over frame bits 127:8 is compared with bits 7:1.
- R9: With busy-wait set and a good short response, go stays set until a strobe sees `dat0_in` at 1. That strobe sets status bit 10 and ends the command with fail 0.
- R10: A command that requests both a long response and busy-wait drives no frame. Go drops, fail is set and no status bit changes.
- R11: Status bits 10:3 are cleared by writing 1 to them. A bit that hardware sets in the same cycle as such a write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| bit_tick | input | 1 | One-cycle strobe per card clock bit |
| cmd_in | input | 1 | Sampled CMD line from the card |
| dat0_in | input | 1 | Sampled DAT0 line, used for busy detection |
| cmd_out | output | 1 | CMD line value while driving |
| cmd_oe | output | 1 | CMD line output enable |

## Verification
A software write-1-to-clear of the status register can land on the same clock edge at which the command engine sets a status bit. The sharpest case is the 64th idle strobe that raises the timeout. The bench first leaves the CRC7 error bit set from an earlier failed response. It then issues a command, gives 63 high strobes, and presents the 64th strobe in the same cycle as a write of ones to every clearable bit. The result is judged by reading the status register afterwards: it must hold the timeout bit alone. That shows the old CRC bit was cleared and the new timeout bit won over the clear.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int RSP_WORDS  = 4;
  localparam int RSP_BITS   = RSP_WORDS * 32;

  // command word bit positions (software visible)
  localparam int CB_GO    = 15;
  localparam int CB_FAIL  = 14;
  localparam int CB_BUSY  = 11;
  localparam int CB_NORSP = 10;
  localparam int CB_LONG  = 9;
  localparam int CB_WR    = 7;
  localparam int CB_RD    = 6;

  // status bit positions
  localparam int SB_BUSY   = 10;
  localparam int SB_CMDTMO = 6;
  localparam int SB_CRC7   = 4;

  // register word addresses
  localparam logic [2:0] A_CMD = 3'd0;
  localparam logic [2:0] A_ARG = 3'd1;
  localparam logic [2:0] A_STS = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_BUSY
  } eng_state_e;

  typedef struct packed {
    logic       busy;
    logic       no_rsp;
    logic       long_rsp;
    logic       wr;
    logic       rd;
    logic [5:0] idx;
  } cmd_fields_t;

  // one serial step of the 7-bit CRC, generator x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    crc7_step = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_head(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    crc7_head = c;
  endfunction

endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);

  logic [6:0] crc_d;

  always_comb begin
    crc_d = crc_o;
    if (clr_i)     crc_d = '0;
    else if (en_i) crc_d = crc7_step(crc_o, bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_o <= '0;
    else        crc_o <= crc_d;
  end

endmodule

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                go_o,
  output cmd_fields_t         fld_o,
  output logic [31:0]         arg_o,
  input  logic                done_i,
  input  logic                fail_i,
  input  logic [10:3]         sts_set_i,
  input  logic                rsp_we_i,
  input  logic                rsp_long_i,
  input  logic [RSP_BITS-1:0] rsp_data_i
);

  logic                go_q, go_d;
  logic                fail_q, fail_d;
  cmd_fields_t         fld_q, fld_d;
  logic [31:0]         arg_q;
  logic [10:3]         sts_q, sts_d;
  logic [RSP_BITS-1:0] rsp_q, rsp_d;

  logic wr_cmd, wr_arg, wr_sts;

  assign wr_cmd = reg_wr && (reg_addr == A_CMD);
  assign wr_arg = reg_wr && (reg_addr == A_ARG);
  assign wr_sts = reg_wr && (reg_addr == A_STS);

  // command word next state: completion has priority, writes only land while idle
  always_comb begin
    go_d   = go_q;
    fail_d = fail_q;
    fld_d  = fld_q;
    if (done_i) begin
      go_d   = 1'b0;
      fail_d = fail_i;
    end else if (wr_cmd && !go_q) begin
      go_d         = reg_wdata[CB_GO];
      fail_d       = 1'b0;
      fld_d.busy     = reg_wdata[CB_BUSY];
      fld_d.no_rsp   = reg_wdata[CB_NORSP];
      fld_d.long_rsp = reg_wdata[CB_LONG];
      fld_d.wr       = reg_wdata[CB_WR];
      fld_d.rd       = reg_wdata[CB_RD];
      fld_d.idx      = reg_wdata[5:0];
    end
  end

  // status: software clears, hardware set wins
  always_comb begin
    sts_d = (sts_q & ~(wr_sts ? reg_wdata[10:3] : 8'h00)) | sts_set_i;
  end

  always_comb begin
    rsp_d = rsp_q;
    if (rsp_long_i) rsp_d = rsp_data_i;
    else            rsp_d[31:0] = rsp_data_i[39:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      fail_q <= 1'b0;
      fld_q  <= '0;
      sts_q  <= '0;
    end else begin
      go_q   <= go_d;
      fail_q <= fail_d;
      fld_q  <= fld_d;
      sts_q  <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arg_q <= '0;
    else if (wr_arg) arg_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_q <= '0;
    else if (rsp_we_i) rsp_q <= rsp_d;
  end

  always_comb begin
    unique case (reg_addr)
      A_CMD:   reg_rdata = {16'h0000, go_q, fail_q, 2'b00, fld_q.busy, fld_q.no_rsp,
                            fld_q.long_rsp, 1'b0, fld_q.wr, fld_q.rd, fld_q.idx};
      A_ARG:   reg_rdata = arg_q;
      A_STS:   reg_rdata = {21'h000000, sts_q, 3'b000};
      default: reg_rdata = reg_addr[2] ? rsp_q[{reg_addr[1:0], 5'b00000} +: 32] : 32'h0;
    endcase
  end

  assign go_o  = go_q;
  assign fld_o = fld_q;
  assign arg_o = arg_q;

  AST_GO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !go_q); // R4
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && go_q && !done_i) |=> (go_q && $stable(fld_q))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && (sts_set_i == 8'h00)) |=> ((sts_q & $past(reg_wdata[10:3])) == 8'h00)); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_set_i) |=> ((sts_q & $past(sts_set_i)) == $past(sts_set_i))); // R11

endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                go_i,
  input  logic                busy_i,
  input  logic                no_rsp_i,
  input  logic                long_i,
  input  logic [5:0]          idx_i,
  input  logic [31:0]         arg_i,
  input  logic                cmd_in,
  input  logic                dat0_in,
  output logic                cmd_out,
  output logic                cmd_oe,
  output logic                done_o,
  output logic                fail_o,
  output logic [10:3]         sts_set_o,
  output logic                rsp_we_o,
  output logic                rsp_long_o,
  output logic [RSP_BITS-1:0] rsp_data_o
);

  localparam int CNT_W = $clog2(LONG_BITS);
  localparam int TMO_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] RX_SHORT  = CNT_W'(FRAME_BITS - 2);
  localparam logic [CNT_W-1:0] RX_LONG   = CNT_W'(LONG_BITS - 2);
  localparam logic [CNT_W-1:0] CRC_LO    = CNT_W'(8);
  localparam logic [CNT_W-1:0] CRC_HI    = CNT_W'(RSP_BITS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST  = TMO_W'(TIMEOUT_CLKS - 1);

  eng_state_e                state_q, state_d;
  logic [FRAME_BITS-1:0]     tx_q, tx_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [TMO_W-1:0]          tmo_q, tmo_d;
  logic [RSP_BITS-2:0]       rx_q, rx_d;
  logic [RSP_BITS-1:0]       rx_shift;
  logic [39:0]               head;
  logic                      crc_clr, crc_en;
  logic [6:0]                crc_val;

  assign head     = {2'b01, idx_i, arg_i};
  assign rx_shift = {rx_q, cmd_in};

  sdc_crc7 u_rx_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .bit_i (cmd_in),
    .crc_o (crc_val)
  );

  always_comb begin
    state_d   = state_q;
    tx_d      = tx_q;
    cnt_d     = cnt_q;
    tmo_d     = tmo_q;
    rx_d      = rx_q;
    done_o    = 1'b0;
    fail_o    = 1'b0;
    sts_set_o = '0;
    rsp_we_o  = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          if (long_i && busy_i) begin
            done_o = 1'b1;
            fail_o = 1'b1;
          end else begin
            state_d = ST_SEND;
            tx_d    = {head, crc7_head(head), 1'b1};
            cnt_d   = TX_LAST;
          end
        end
      end
      ST_SEND: begin
        if (tick_i) begin
          tx_d = {tx_q[FRAME_BITS-2:0], 1'b1};
          if (cnt_q == '0) begin
            if (no_rsp_i) begin
              done_o  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              tmo_d   = '0;
              state_d = ST_WAIT;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (tick_i) begin
          if (!cmd_in) begin
            crc_clr = 1'b1;
            cnt_d   = long_i ? RX_LONG : RX_SHORT;
            state_d = ST_RECV;
          end else if (tmo_q == TMO_LAST) begin
            done_o               = 1'b1;
            fail_o               = 1'b1;
            sts_set_o[SB_CMDTMO] = 1'b1;
            state_d              = ST_IDLE;
          end else begin
            tmo_d = tmo_q + TMO_W'(1);
          end
        end
      end
      ST_RECV: begin
        if (tick_i) begin
          rx_d   = rx_shift[RSP_BITS-2:0];
          crc_en = (cnt_q >= CRC_LO) && (cnt_q <= CRC_HI);
          if (cnt_q == '0) begin
            rsp_we_o = 1'b1;
            if (crc_val != rx_q[6:0]) begin
              done_o             = 1'b1;
              fail_o             = 1'b1;
              sts_set_o[SB_CRC7] = 1'b1;
              state_d            = ST_IDLE;
            end else if (busy_i && !long_i) begin
              state_d = ST_BUSY;
            end else begin
              done_o  = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_BUSY: begin
        if (tick_i && dat0_in) begin
          done_o             = 1'b1;
          sts_set_o[SB_BUSY] = 1'b1;
          state_d            = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= '1;
      cnt_q   <= '0;
      tmo_q   <= '0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
      rx_q    <= rx_d;
    end
  end

  assign cmd_oe     = (state_q == ST_SEND);
  assign cmd_out    = (state_q == ST_SEND) ? tx_q[FRAME_BITS-1] : 1'b1;
  assign rsp_long_o = long_i;
  assign rsp_data_o = rx_shift;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |-> !cmd_oe); // R3
  AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go_i && long_i && busy_i) |=> !cmd_oe); // R10
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sts_set_o) <= 1); // R6
  AST_CAUSE_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_set_o) |=> !cmd_oe); // R9

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bit_tick,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        cmd_out,
  output logic        cmd_oe
);

  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic                go;
  cmd_fields_t         fld;
  logic [31:0]         arg;
  logic                done, fail, rsp_we, rsp_long;
  logic [10:3]         sts_set;
  logic [RSP_BITS-1:0] rsp_data;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sdc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .go_o       (go),
    .fld_o      (fld),
    .arg_o      (arg),
    .done_i     (done),
    .fail_i     (fail),
    .sts_set_i  (sts_set),
    .rsp_we_i   (rsp_we),
    .rsp_long_i (rsp_long),
    .rsp_data_i (rsp_data)
  );

  sdc_cmd_engine #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick_i     (bit_tick),
    .go_i       (go),
    .busy_i     (fld.busy),
    .no_rsp_i   (fld.no_rsp),
    .long_i     (fld.long_rsp),
    .idx_i      (fld.idx),
    .arg_i      (arg),
    .cmd_in     (cmd_in),
    .dat0_in    (dat0_in),
    .cmd_out    (cmd_out),
    .cmd_oe     (cmd_oe),
    .done_o     (done),
    .fail_o     (fail),
    .sts_set_o  (sts_set),
    .rsp_we_o   (rsp_we),
    .rsp_long_o (rsp_long),
    .rsp_data_o (rsp_data)
  );

endmodule

// File: tb/sdcmd_issue_test.sv
module sdcmd_issue_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        bit_tick = 1'b0;
  logic        cmd_in = 1'b1;
  logic        dat0_in = 1'b1;
  logic        cmd_out, cmd_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sdcmd_issue uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
    .cmd_in(cmd_in), .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe)
  );

  function automatic logic [6:0] m_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c;
    c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb;
      fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] m_cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [135:0] t;
    t = {88'h0, 2'b01, idx, arg, 8'h00};
    return {2'b01, idx, arg, m_crc(t, 47, 8), 1'b1};
  endfunction

  function automatic logic [47:0] m_short_rsp(input logic [5:0] idx, input logic [31:0] body);
    logic [135:0] t;
    t = {88'h0, 2'b00, idx, body, 8'h00};
    return {2'b00, idx, body, m_crc(t, 47, 8), 1'b1};
  endfunction

  function automatic logic [135:0] m_long_rsp(input logic [119:0] body);
    logic [135:0] t;
    t = {8'h3F, body, 8'h00};
    t[7:1] = m_crc(t, 127, 8);
    t[0] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick(input logic ci, input logic d0);
    @(negedge clk);
    cmd_in = ci; dat0_in = d0; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; cmd_in = 1'b1; dat0_in = 1'b1;
  endtask

  // start a command and capture the driven frame; optional write mid-frame (R5)
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] flags,
                       input int poke_at);
    logic [47:0] got, exp;
    logic [31:0] v;
    int oe_cnt;
    oe_cnt = 0;
    bus_wr(3'd1, arg);
    bus_wr(3'd0, {16'h0, 16'h8000 | flags | {10'h0, idx}});
    repeat (2) @(negedge clk);
    for (int i = 47; i >= 0; i--) begin
      got[i] = cmd_out;
      if (cmd_oe) oe_cnt++;
      if (i == poke_at) begin
        bus_wr(3'd0, 32'h0000_0003);
        bus_rd(3'd0, v);
        chk("R5", "cmd word after write while busy", v, {16'h0, 16'h8000 | flags | {10'h0, idx}});
      end
      tick(1'b1, 1'b1);
    end
    exp = m_cmd_frame(idx, arg);
    chk("R3", "frame high", {16'h0, got[47:32]}, {16'h0, exp[47:32]});
    chk("R3", "frame low", got[31:0], exp[31:0]);
    chk("R3", "oe bit count", oe_cnt, 48);
    chk("R3", "oe after frame", {31'h0, cmd_oe}, 32'h0);
  endtask

  task automatic send_short(input logic [5:0] idx, input logic [31:0] body, input logic bad);
    logic [47:0] f;
    f = m_short_rsp(idx, body);
    if (bad) f[3] = ~f[3];
    for (int i = 47; i >= 0; i--) tick(f[i], 1'b1);
  endtask

  task automatic send_long(input logic [135:0] f);
    for (int i = 135; i >= 0; i--) tick(f[i], 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [135:0] lf;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      if (a != 3) begin
        bus_rd(3'(a), v);
        chk("R1", "reset register", v, 32'h0);
      end
    end
    chk("R1", "oe/out at reset", {30'h0, cmd_oe, cmd_out}, 32'h1);

    // R2 field readback without go, fail and bit 8 not settable
    bus_wr(3'd0, 32'h0000_43C5);
    bus_rd(3'd0, v);
    chk("R2", "cmd readback", v, 32'h0000_02C5);
    bus_wr(3'd1, 32'hA5C3_1E0F);
    bus_rd(3'd1, v);
    chk("R2", "arg readback", v, 32'hA5C3_1E0F);
    repeat (3) @(negedge clk);
    chk("R2", "no drive without go", {31'h0, cmd_oe}, 32'h0);

    // R4 no-response command
    issue(6'd0, 32'h0, 16'h0400, -1);
    bus_rd(3'd0, v);
    chk("R4", "no-resp done", v, 32'h0000_0400);

    // R5 write during frame, then short response R7
    issue(6'd17, 32'h1234_5678, 16'h0000, 20);
    repeat (3) tick(1'b1, 1'b1);
    send_short(6'd17, 32'hCAFE_0001, 1'b0);
    bus_rd(3'd0, v);
    chk("R7", "short ok cmd", v, 32'h0000_0011);
    bus_rd(3'd4, v);
    chk("R7", "short word0", v, 32'hCAFE_0001);

    // R6 timeout: 63 highs keep go, 64th ends
    issue(6'd1, 32'h0, 16'h0000, -1);
    repeat (63) tick(1'b1, 1'b1);
    bus_rd(3'd0, v);
    chk("R6", "go held at 63", v, 32'h0000_8001);
    tick(1'b1, 1'b1);
    bus_rd(3'd0, v);
    chk("R6", "timeout cmd", v, 32'h0000_4001);
    bus_rd(3'd2, v);
    chk("R6", "timeout status", v, 32'h0000_0040);
    bus_wr(3'd2, 32'h0000_07F8);

    // R6 boundary: start bit on the 64th strobe accepted
    issue(6'd2, 32'h55AA_55AA, 16'h0000, -1);
    repeat (63) tick(1'b1, 1'b1);
    send_short(6'd2, 32'h0BAD_F00D, 1'b0);
    bus_rd(3'd0, v);
    chk("R6", "late start ok", v, 32'h0000_0002);
    bus_rd(3'd4, v);
    chk("R6", "late start word0", v, 32'h0BAD_F00D);

    // R7 CRC error leaves status bit 4 set for the collision test
    issue(6'd3, 32'h0, 16'h0000, -1);
    send_short(6'd3, 32'h1111_2222, 1'b1);
    bus_rd(3'd0, v);
    chk("R7", "crc fail cmd", v, 32'h0000_4003);
    bus_rd(3'd2, v);
    chk("R7", "crc status", v, 32'h0000_0010);

    // R11 clear-all write in the same cycle as the timeout set
    issue(6'd4, 32'h0, 16'h0000, -1);
    repeat (63) tick(1'b1, 1'b1);
    @(negedge clk);
    cmd_in = 1'b1; bit_tick = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_07F8;
    @(negedge clk);
    bit_tick = 1'b0; reg_wr = 1'b0;
    bus_rd(3'd2, v);
    chk("R11", "set beats clear", v, 32'h0000_0040);
    bus_wr(3'd2, 32'h0000_0040);
    bus_rd(3'd2, v);
    chk("R11", "w1c clears", v, 32'h0);

    // R9 busy wait
    issue(6'd7, 32'hFFFF_0000, 16'h0800, -1);
    send_short(6'd7, 32'h0000_0900, 1'b0);
    repeat (5) tick(1'b1, 1'b0);
    bus_rd(3'd0, v);
    chk("R9", "go held while busy", v, 32'h0000_8807);
    tick(1'b1, 1'b1);
    bus_rd(3'd0, v);
    chk("R9", "busy done cmd", v, 32'h0000_0807);
    bus_rd(3'd2, v);
    chk("R9", "busy status", v, 32'h0000_0400);
    bus_wr(3'd2, 32'h0000_07F8);

    // R10 long + busy rejected
    bus_wr(3'd0, 32'h0000_8A09);
    chk("R10", "no drive on reject", {31'h0, cmd_oe}, 32'h0);
    repeat (2) @(negedge clk);
    bus_rd(3'd0, v);
    chk("R10", "reject cmd", v, 32'h0000_4A09);
    bus_rd(3'd2, v);
    chk("R10", "reject status", v, 32'h0);

    // random mix of command kinds
    for (int n = 0; n < 24; n++) begin
      logic [5:0]  idx;
      logic [31:0] arg, body;
      int kind;
      idx  = 6'($urandom % 64);
      arg  = $urandom;
      body = $urandom;
      kind = int'($urandom % 4);
      bus_wr(3'd2, 32'h0000_07F8);
      case (kind)
        0: begin
          issue(idx, arg, 16'h0400, -1);
          bus_rd(3'd0, v);
          chk("R4", "rand no-resp", v, 32'h0000_0400 | {26'h0, idx});
        end
        1, 2: begin
          issue(idx, arg, 16'h0000, -1);
          repeat ($urandom % 10) tick(1'b1, 1'b1);
          send_short(idx, body, kind == 2);
          bus_rd(3'd0, v);
          chk("R7", "rand short cmd", v, (kind == 2 ? 32'h4000 : 32'h0) | {26'h0, idx});
          bus_rd(3'd2, v);
          chk("R7", "rand short status", v, kind == 2 ? 32'h10 : 32'h0);
          if (kind == 1) begin
            bus_rd(3'd4, v);
            chk("R7", "rand short word0", v, body);
          end
        end
        default: begin
          lf = m_long_rsp({$urandom, $urandom, $urandom, $urandom} >> 8);
          issue(idx, arg, 16'h0200, -1);
          repeat ($urandom % 10) tick(1'b1, 1'b1);
          send_long(lf);
          bus_rd(3'd0, v);
          chk("R8", "rand long cmd", v, 32'h0000_0200 | {26'h0, idx});
          for (int w = 0; w < 4; w++) begin
            bus_rd(3'(4 + w), v);
            chk("R8", "rand long word", v, lf[32*w +: 32]);
          end
        end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule